// File: doc/BRIEF.md
# Storage Access Exception Classifier

This block looks at the outcome of one data access and one instruction fetch in each cycle. It decides whether a data storage exception (vector offset 0x00300) or an instruction storage exception (vector offset 0x00400) must be taken. For a data access it uses:
- the access kind,
- whether the translation lookaside buffer missed,
- whether the hardware table search that followed ended in a page fault,
- the write-through attribute of the page,
- the direct-store flag of the segment.

For a fetch it uses:
- whether the address could be translated,
- the no-execute flag of the segment,
- the guarded attribute,
- whether instruction relocation is on.

The result is registered. It appears one cycle after the valid inputs as a single-cycle strobe, together with the vector offset and a cause code. The cause code has one bit per condition, and the data and instruction causes sit in separate fields. A pending higher-priority exception suppresses the result completely. A floating-point access to a direct-store segment is classified as a data storage exception and never as an alignment exception.

Top module: `sax_classifier`

## Requirements
- R1: While rst_ni is low, exc_o is 0, vec_o is 0 and cause_o is 0.
- R2: A valid data access of any kind other than none (kind 7) that has both a TLB miss and a page fault from the table walk sets cause bit 0. A TLB miss with no page fault raises nothing, and a page-fault input without a TLB miss is ignored.
- R3: A reserved load (kind 3) or a conditional store (kind 4) to a write-through page sets cause bit 1. Write-through on any other kind raises nothing.
- R4: Any load or store to a direct-store segment sets cause bit 2. This covers load 0, store 1, reserved load 3, conditional store 4, FP load 5 and FP store 6. A cache operation (kind 2) to a direct-store segment raises nothing.
- R5: An FP load or FP store to a direct-store segment raises exc_o with vec_o = 0x00300. No other vector is used for it.
- R6: A valid fetch whose address cannot be translated raises exc_o with vec_o = 0x00400 and sets cause bit 3.
- R7: A valid fetch to a no-execute segment sets cause bit 4 with vec_o = 0x00400.
- R8: A fetch to guarded storage sets cause bit 5 only while relocation is on. With relocation off, the guarded attribute is ignored.
- R9: While hi_pend_i is high, no exception is raised in the following cycle, whatever the other inputs are.
- R10: When several data conditions hold together, all their cause bits are set under one strobe, in one cycle.
- R11: When a data fault and a fetch fault occur in the same cycle, the data exception is reported: vec_o = 0x00300 and cause bits 5:3 are 0.
- R12: Outputs change one clock edge after the inputs are sampled. exc_o is high for exactly the cycles that follow a faulting input cycle. vec_o and cause_o are 0 whenever exc_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hi_pend_i | input | 1 | A higher-priority exception is pending |
| d_valid_i | input | 1 | Data access result is valid |
| d_kind_i | input | 3 | Access kind: 0 load, 1 store, 2 cache op, 3 reserved load, 4 conditional store, 5 FP load, 6 FP store, 7 none |
| d_tlb_miss_i | input | 1 | TLB missed for the data access |
| d_walk_fault_i | input | 1 | Table walk ended in a page fault |
| d_wt_i | input | 1 | Page is write-through |
| d_dseg_i | input | 1 | Segment is direct-store |
| f_valid_i | input | 1 | Fetch result is valid |
| f_xlate_fail_i | input | 1 | Fetch address could not be translated |
| f_noexec_i | input | 1 | Fetch segment is no-execute |
| f_guarded_i | input | 1 | Fetch is to guarded storage |
| f_reloc_i | input | 1 | Instruction relocation enabled |
| exc_o | output | 1 | Exception strobe |
| vec_o | output | VEC_W (20) | Vector offset, 0x00300 or 0x00400 |
| cause_o | output | 6 | Bits 2:0 data (page fault, write-through reservation, direct-store); bits 5:3 fetch (untranslated, no-execute, guarded) |

## Verification
Two events can land in the same cycle: a data fault and a fetch fault. Several data conditions can also coincide, for example a page fault, a direct-store segment and a write-through reservation together. The bench provokes both cases directly. It also reaches them through random stimulus biased so that faults are common. The data exception must win with an empty fetch field, and every coinciding data bit must appear under the one strobe. Each outcome is compared, one edge later, with a value the bench computes from the requirements. Cycles with hi_pend_i high are mixed in throughout, and they must produce silence.

// File: rtl/sax_pkg.sv
package sax_pkg;
  localparam int DC_W    = 3;
  localparam int IC_W    = 3;
  localparam int CAUSE_W = DC_W + IC_W;
  localparam int KIND_W  = 3;

  typedef enum logic [KIND_W-1:0] {
    AK_LOAD    = 3'd0,
    AK_STORE   = 3'd1,
    AK_CACHE   = 3'd2,
    AK_RESV_LD = 3'd3,
    AK_COND_ST = 3'd4,
    AK_FP_LD   = 3'd5,
    AK_FP_ST   = 3'd6,
    AK_NONE    = 3'd7
  } acc_kind_e;

  typedef struct packed {
    logic dseg;
    logic wt_resv;
    logic pg_fault;
  } dcause_t;

  typedef struct packed {
    logic guard;
    logic noexec;
    logic xlate;
  } icause_t;
endpackage

// File: rtl/sax_data_chk.sv
module sax_data_chk
  import sax_pkg::*;
(
  input  logic              valid_i,
  input  logic [KIND_W-1:0] kind_i,
  input  logic              tlb_miss_i,
  input  logic              walk_fault_i,
  input  logic              wt_i,
  input  logic              dseg_i,
  output dcause_t           cause_o
);
  acc_kind_e kind;
  logic is_acc, is_ldst, is_resv;

  always_comb begin
    kind    = acc_kind_e'(kind_i);
    is_acc  = valid_i && (kind != AK_NONE);
    is_ldst = is_acc && (kind != AK_CACHE);
    is_resv = (kind == AK_RESV_LD) || (kind == AK_COND_ST);
    cause_o.pg_fault = is_acc && tlb_miss_i && walk_fault_i;
    cause_o.wt_resv  = is_acc && is_resv && wt_i;
    // FP accesses land here too, never on the alignment path
    cause_o.dseg     = is_ldst && dseg_i;
  end
endmodule

// File: rtl/sax_fetch_chk.sv
module sax_fetch_chk
  import sax_pkg::*;
(
  input  logic    valid_i,
  input  logic    xlate_fail_i,
  input  logic    noexec_i,
  input  logic    guarded_i,
  input  logic    reloc_i,
  output icause_t cause_o
);
  always_comb begin
    cause_o.xlate  = valid_i && xlate_fail_i;
    cause_o.noexec = valid_i && noexec_i;
    cause_o.guard  = valid_i && guarded_i && reloc_i;
  end
endmodule

// File: rtl/sax_exc_sel.sv
module sax_exc_sel
  import sax_pkg::*;
#(
  parameter int               VEC_W   = 20,
  parameter logic [VEC_W-1:0] DSI_VEC = VEC_W'('h00300),
  parameter logic [VEC_W-1:0] ISI_VEC = VEC_W'('h00400)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               block_i,
  input  dcause_t            dcause_i,
  input  icause_t            icause_i,
  output logic               exc_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic               d_hit, i_hit, take;
  logic [VEC_W-1:0]   vec_d;
  logic [CAUSE_W-1:0] cause_d;

  always_comb begin
    d_hit   = |dcause_i;
    i_hit   = |icause_i;
    take    = !block_i && (d_hit || i_hit);
    vec_d   = '0;
    cause_d = '0;
    if (take) begin
      if (d_hit) begin
        // data fault outranks the fetch fault of the same cycle
        vec_d   = DSI_VEC;
        cause_d = {{IC_W{1'b0}}, dcause_i};
      end else begin
        vec_d   = ISI_VEC;
        cause_d = {icause_i, {DC_W{1'b0}}};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exc_o   <= 1'b0;
      vec_o   <= '0;
      cause_o <= '0;
    end else begin
      exc_o   <= take;
      vec_o   <= vec_d;
      cause_o <= cause_d;
    end
  end
endmodule

// File: rtl/sax_classifier.sv
module sax_classifier
  import sax_pkg::*;
#(
  parameter int VEC_W = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hi_pend_i,
  input  logic               d_valid_i,
  input  logic [KIND_W-1:0]  d_kind_i,
  input  logic               d_tlb_miss_i,
  input  logic               d_walk_fault_i,
  input  logic               d_wt_i,
  input  logic               d_dseg_i,
  input  logic               f_valid_i,
  input  logic               f_xlate_fail_i,
  input  logic               f_noexec_i,
  input  logic               f_guarded_i,
  input  logic               f_reloc_i,
  output logic               exc_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic [CAUSE_W-1:0] cause_o
);
  dcause_t dcause;
  icause_t icause;

  sax_data_chk u_data (
    .valid_i      (d_valid_i),
    .kind_i       (d_kind_i),
    .tlb_miss_i   (d_tlb_miss_i),
    .walk_fault_i (d_walk_fault_i),
    .wt_i         (d_wt_i),
    .dseg_i       (d_dseg_i),
    .cause_o      (dcause)
  );

  sax_fetch_chk u_fetch (
    .valid_i      (f_valid_i),
    .xlate_fail_i (f_xlate_fail_i),
    .noexec_i     (f_noexec_i),
    .guarded_i    (f_guarded_i),
    .reloc_i      (f_reloc_i),
    .cause_o      (icause)
  );

  sax_exc_sel #(
    .VEC_W   (VEC_W),
    .DSI_VEC (VEC_W'('h00300)),
    .ISI_VEC (VEC_W'('h00400))
  ) u_sel (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .block_i  (hi_pend_i),
    .dcause_i (dcause),
    .icause_i (icause),
    .exc_o    (exc_o),
    .vec_o    (vec_o),
    .cause_o  (cause_o)
  );
endmodule

// File: rtl/sax_classifier_chk.sv
module sax_classifier_chk
  import sax_pkg::*;
#(
  parameter int VEC_W = 20
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               hi_pend_i,
  input logic               d_valid_i,
  input logic [KIND_W-1:0]  d_kind_i,
  input logic               d_tlb_miss_i,
  input logic               d_walk_fault_i,
  input logic               f_valid_i,
  input logic               f_xlate_fail_i,
  input logic               f_guarded_i,
  input logic               f_reloc_i,
  input logic               exc_o,
  input logic [VEC_W-1:0]   vec_o,
  input logic [CAUSE_W-1:0] cause_o
);
  localparam logic [VEC_W-1:0] DSI = VEC_W'('h00300);
  localparam logic [VEC_W-1:0] ISI = VEC_W'('h00400);

  a_r9_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(hi_pend_i) |-> !exc_o);

  a_r12_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_o |-> (cause_o == '0 && vec_o == '0));

  a_r11_data_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_o && cause_o[DC_W-1:0] != '0) |-> (cause_o[CAUSE_W-1:DC_W] == '0 && vec_o == DSI));

  a_r6_untranslated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(f_valid_i && f_xlate_fail_i && !d_valid_i && !hi_pend_i)
      |-> (exc_o && vec_o == ISI && cause_o[3]));

  a_r8_unrelocated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(f_guarded_i && !f_reloc_i) |-> !cause_o[5]);

  a_r2_walk_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(d_valid_i && d_kind_i != 3'd7 && d_tlb_miss_i && d_walk_fault_i && !hi_pend_i)
      |-> (exc_o && cause_o[0]));
endmodule

bind sax_classifier sax_classifier_chk #(.VEC_W(VEC_W)) chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .hi_pend_i      (hi_pend_i),
  .d_valid_i      (d_valid_i),
  .d_kind_i       (d_kind_i),
  .d_tlb_miss_i   (d_tlb_miss_i),
  .d_walk_fault_i (d_walk_fault_i),
  .f_valid_i      (f_valid_i),
  .f_xlate_fail_i (f_xlate_fail_i),
  .f_guarded_i    (f_guarded_i),
  .f_reloc_i      (f_reloc_i),
  .exc_o          (exc_o),
  .vec_o          (vec_o),
  .cause_o        (cause_o)
);

// File: tb/sax_classifier_tb.sv
`timescale 1ns/1ps
module sax_classifier_tb_top;
  localparam int VEC_W = 20;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic hi_pend_i = 0, d_valid_i = 0, d_tlb_miss_i = 0, d_walk_fault_i = 0, d_wt_i = 0, d_dseg_i = 0;
  logic [2:0] d_kind_i = 3'd7;
  logic f_valid_i = 0, f_xlate_fail_i = 0, f_noexec_i = 0, f_guarded_i = 0, f_reloc_i = 0;
  logic exc_o;
  logic [VEC_W-1:0] vec_o;
  logic [5:0] cause_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  sax_classifier #(.VEC_W(VEC_W)) dut_i (.*);

  // expected {exc, vec, cause} from the requirements
  function automatic logic [26:0] model();
    logic [2:0] dc, ic;
    logic acc, mem, resv;
    acc  = d_valid_i && d_kind_i != 3'd7;
    mem  = acc && d_kind_i != 3'd2;
    resv = d_kind_i == 3'd3 || d_kind_i == 3'd4;
    dc = {mem && d_dseg_i, acc && resv && d_wt_i, acc && d_tlb_miss_i && d_walk_fault_i};
    ic = {f_valid_i && f_guarded_i && f_reloc_i, f_valid_i && f_noexec_i, f_valid_i && f_xlate_fail_i};
    if (hi_pend_i) return '0;
    if (dc != 0) return {1'b1, 20'h00300, 3'b000, dc};
    if (ic != 0) return {1'b1, 20'h00400, ic, 3'b000};
    return '0;
  endfunction

  task automatic cmp(input string req);
    logic [26:0] exp;
    exp = model();
    @(negedge clk_i);
    checks++;
    if ({exc_o, vec_o, cause_o} !== exp) begin
      errors++;
      $display("FAIL %s: got exc=%0b vec=%05h cause=%06b exp exc=%0b vec=%05h cause=%06b",
               req, exc_o, vec_o, cause_o, exp[26], exp[25:6], exp[5:0]);
    end
  endtask

  task automatic idle();
    hi_pend_i = 0; d_valid_i = 0; d_kind_i = 3'd7; d_tlb_miss_i = 0; d_walk_fault_i = 0;
    d_wt_i = 0; d_dseg_i = 0; f_valid_i = 0; f_xlate_fail_i = 0; f_noexec_i = 0;
    f_guarded_i = 0; f_reloc_i = 0;
  endtask

  task automatic dacc(input logic [2:0] k, input logic miss, flt, wt, ds);
    idle(); d_valid_i = 1; d_kind_i = k; d_tlb_miss_i = miss; d_walk_fault_i = flt;
    d_wt_i = wt; d_dseg_i = ds;
  endtask

  task automatic fetch(input logic xf, ne, g, rl);
    f_valid_i = 1; f_xlate_fail_i = xf; f_noexec_i = ne; f_guarded_i = g; f_reloc_i = rl;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    idle();
    // R1 reset state
    dacc(3'd0, 1, 1, 0, 1); fetch(1, 1, 1, 1);
    repeat (3) @(negedge clk_i);
    checks++;
    if ({exc_o, vec_o, cause_o} !== '0) begin
      errors++;
      $display("FAIL R1: got %h exp 0", {exc_o, vec_o, cause_o});
    end
    idle();
    @(negedge clk_i); rst_ni = 1;
    @(negedge clk_i);

    // R2
    dacc(3'd0, 1, 1, 0, 0); cmp("R2 load page fault");
    dacc(3'd2, 1, 1, 0, 0); cmp("R2 cache op page fault");
    dacc(3'd1, 1, 0, 0, 0); cmp("R2 miss without fault");
    dacc(3'd1, 0, 1, 0, 0); cmp("R2 fault without miss ignored");
    dacc(3'd7, 1, 1, 1, 1); cmp("R2 kind none");
    // R3
    dacc(3'd3, 0, 0, 1, 0); cmp("R3 reserved load write-through");
    dacc(3'd4, 0, 0, 1, 0); cmp("R3 conditional store write-through");
    dacc(3'd1, 0, 0, 1, 0); cmp("R3 plain store write-through");
    // R4
    for (int k = 0; k < 7; k++) begin
      dacc(3'(k), 0, 0, 0, 1); cmp("R4 direct-store by kind");
    end
    // R5
    dacc(3'd5, 0, 0, 0, 1); cmp("R5 fp load direct-store");
    dacc(3'd6, 0, 0, 0, 1); cmp("R5 fp store direct-store");
    // R6 R7 R8
    idle(); fetch(1, 0, 0, 0); cmp("R6 untranslated fetch");
    idle(); fetch(0, 1, 0, 0); cmp("R7 no-execute fetch");
    idle(); fetch(0, 0, 1, 1); cmp("R8 guarded relocated");
    idle(); fetch(0, 0, 1, 0); cmp("R8 guarded unrelocated");
    idle(); fetch(1, 1, 1, 1); cmp("R8 all fetch causes");
    // R9
    dacc(3'd3, 1, 1, 1, 1); fetch(1, 1, 1, 1); hi_pend_i = 1; cmp("R9 blocked");
    // R10
    dacc(3'd4, 1, 1, 1, 1); cmp("R10 three data causes");
    // R11
    dacc(3'd0, 1, 1, 0, 0); fetch(1, 1, 0, 0); cmp("R11 data beats fetch");
    // R12 strobe drops after one cycle
    idle(); cmp("R12 strobe ends");

    for (int i = 0; i < 2000; i++) begin
      idle();
      hi_pend_i      = ($urandom % 8) == 0;
      d_valid_i      = $urandom % 2;
      d_kind_i       = 3'($urandom);
      d_tlb_miss_i   = $urandom % 2;
      d_walk_fault_i = $urandom % 2;
      d_wt_i         = ($urandom % 4) == 0;
      d_dseg_i       = ($urandom % 4) == 0;
      f_valid_i      = $urandom % 2;
      f_xlate_fail_i = ($urandom % 4) == 0;
      f_noexec_i     = ($urandom % 4) == 0;
      f_guarded_i    = $urandom % 2;
      f_reloc_i      = $urandom % 2;
      cmp("R12 random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule